// File: doc/BRIEF.md
# Multi-Bank Asynchronous Memory Controller

This block connects one internal request port to an external asynchronous memory bus that serves up to four attached devices. The request carries a 28-bit word address, 16 bits of write data and a read/write flag. The controller checks which of four fixed, non-contiguous address windows holds the address. It then drives that window's active-low select line and runs a bus cycle in three phases: address setup, strobe active and hold. Each bank sets the length of each phase in its own timing register.

A read returns its data together with a one-cycle done pulse. A request that falls in a gap between windows gets done and error in the next cycle, and no select line moves. A small write port loads the timing registers, one bank per write. The timing of a bank is copied into the cycle engine at the moment a request is accepted. A register write in that same cycle therefore affects only later cycles.

The cycle engine has six named states. IDLE is the only state that accepts requests. SETUP holds the select with both strobes released. ACCESS pulls the read or write strobe low. HOLD keeps the select after the strobe is released. FINISH issues done after a mapped cycle. REJECT issues done with error after an unmapped request. The transitions are as follows:
- IDLE goes to SETUP when the request is valid and the address is mapped.
- IDLE goes to REJECT when the request is valid and the address is unmapped.
- SETUP goes to ACCESS when its count reaches zero.
- ACCESS goes to HOLD when its count reaches zero.
- HOLD goes to FINISH when its count reaches zero.
- FINISH goes to IDLE unconditionally.
- REJECT goes to IDLE unconditionally.

Top module: `xbc_top`

## Requirements
- R1: Bank b is mapped only in these word address windows: bank 0 from 0x0020_0000 to 0x007F_FFFF, bank 1 from 0x0400_0000 to 0x047F_FFFF, bank 2 from 0x0800_0000 to 0x087F_FFFF, and bank 3 from 0x0C00_0000 to 0x0C7F_FFFF. A mapped access drives bit b of `mem_cs_n` low, and only that bit. The select does not change while a cycle runs.
- R2: A request whose address is in no window raises `rsp_done` and `rsp_err` together for one cycle, in the cycle after acceptance. No bit of `mem_cs_n` and no strobe goes low.
- R3: For a bank with setup field S, strobe field A and hold field H, the select stays low for S+A+H+3 cycles. The strobe goes low after the first S+1 of those cycles and stays low for A+1 cycles. A field value of 0 means one cycle.
- R4: A write with `cfg_we` high loads `cfg_timing` into the bank chosen by `cfg_bank`. The field layout is bits [3:0] setup, [7:4] strobe and [11:8] hold. Each bank keeps its own value.
- R5: `rsp_done` is high for exactly one cycle, the cycle right after the last hold cycle. On a read, `rsp_rdata` then shows the value of `mem_rdata` sampled on the last clock edge of the strobe phase.
- R6: On a write, `mem_wr_n` is low during the strobe phase and `mem_rd_n` stays high. `mem_wdata` shows the request data, and `mem_wdata_oe` is high while the select is low. On a read, `mem_wr_n` stays high and `mem_wdata_oe` stays low.
- R7: `req_ready` is high only in IDLE. A request presented while the controller is busy is ignored and does not change the running cycle.
- R8: The timing used by a cycle is the bank's register value at acceptance. A write to that bank in the accept cycle applies from the next request onward.
- R9: After reset all selects and strobes are high, `req_ready` is high, `rsp_done` and `rsp_err` are low, and every timing field is 0.
- R10: While a select is low, `mem_addr` equals bits [22:0] of the accepted word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Unmapped address, valid with done |
| rsp_rdata | output | 16 | Read data |
| cfg_we | input | 1 | Timing register write enable |
| cfg_bank | input | 2 | Bank whose timing is written |
| cfg_timing | input | 12 | {hold, strobe, setup}, 4 bits each |
| mem_cs_n | output | 4 | Active-low bank selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_addr | output | 23 | External word address |
| mem_wdata | output | 16 | External write data |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | 16 | External read data |

## Verification
A timing register write and a request acceptance can fall on the same clock edge, and both can name the same bank. The bench provokes this by asserting `cfg_we` together with `req_valid` while the controller is in IDLE. It judges the result by counting strobe-low cycles on that request and on the next request to the same bank. The first count must follow the old strobe field and the second count must follow the new one.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
    parameter int NBANK  = 4;
    parameter int TF_W   = 4;
    localparam int BSEL_W = $clog2(NBANK);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD,
        ST_FINISH,
        ST_REJECT
    } xbc_state_e;

    typedef struct packed {
        logic [TF_W-1:0] hold;
        logic [TF_W-1:0] strobe;
        logic [TF_W-1:0] setup;
    } xbc_timing_t;
endpackage

// File: rtl/xbc_decode.sv
module xbc_decode
    import xbc_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int WIN_W     = 23,
    parameter int STRIDE_W  = 26,
    parameter int BANK0_OFS = 32'h0020_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BSEL_W-1:0] bank
);
    logic [NBANK-1:0] win_hit;

    for (genvar b = 0; b < NBANK; b++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(b) << STRIDE_W;
        localparam logic [ADDR_W-1:0] LO   = (b == 0) ? ADDR_W'(BANK0_OFS) : BASE;
        localparam logic [ADDR_W-1:0] HI   = BASE + ((ADDR_W'(1) << WIN_W) - ADDR_W'(1));
        assign win_hit[b] = (addr >= LO) && (addr <= HI);
    end

    always_comb begin
        hit  = |win_hit;
        bank = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (win_hit[b]) bank = BSEL_W'(b);
        end
    end

    always_comb begin
        assert_win_exclusive_R1: assert ($onehot0(win_hit));
    end
endmodule

// File: rtl/xbc_timing_regs.sv
module xbc_timing_regs
    import xbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BSEL_W-1:0] wr_bank,
    input  xbc_timing_t       wr_val,
    input  logic [BSEL_W-1:0] rd_bank,
    output xbc_timing_t       rd_val
);
    xbc_timing_t regs_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[b] <= '0;
            end else if (wr_en && (wr_bank == BSEL_W'(b))) begin
                regs_q[b] <= wr_val;
            end
        end
    end

    assign rd_val = regs_q[rd_bank];
endmodule

// File: rtl/xbc_cycle_fsm.sv
module xbc_cycle_fsm
    import xbc_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 16,
    parameter int MADR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              dec_hit,
    input  logic [BSEL_W-1:0] dec_bank,
    input  xbc_timing_t       bank_tim,
    output logic [NBANK-1:0]  mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [MADR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    input  logic [DATA_W-1:0] mem_rdata
);
    xbc_state_e        state_q, state_d;
    logic [TF_W-1:0]   cnt_q;
    xbc_timing_t       tim_q;
    logic [BSEL_W-1:0] bank_q;
    logic              write_q;
    logic [MADR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              cnt_zero;
    logic              accept;

    assign cnt_zero = (cnt_q == '0);
    assign accept   = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = dec_hit ? ST_SETUP : ST_REJECT;
            ST_SETUP:  if (cnt_zero) state_d = ST_ACCESS;
            ST_ACCESS: if (cnt_zero) state_d = ST_HOLD;
            ST_HOLD:   if (cnt_zero) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // cycle datapath: request latch, phase counter, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tim_q   <= '0;
            bank_q  <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && dec_hit) begin
                        tim_q   <= bank_tim;
                        cnt_q   <= bank_tim.setup;
                        bank_q  <= dec_bank;
                        write_q <= req_write;
                        addr_q  <= req_addr[MADR_W-1:0];
                        wdata_q <= req_wdata;
                    end
                end
                ST_SETUP: begin
                    cnt_q <= cnt_zero ? tim_q.strobe : cnt_q - 1'b1;
                end
                ST_ACCESS: begin
                    if (cnt_zero) begin
                        cnt_q <= tim_q.hold;
                        if (!write_q) rdata_q <= mem_rdata;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
                end
                ST_FINISH, ST_REJECT: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        logic sel_on;
        logic strobe_on;
        sel_on    = 1'b0;
        strobe_on = 1'b0;
        req_ready = 1'b0;
        rsp_done  = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_SETUP:  sel_on    = 1'b1;
            ST_ACCESS: begin
                sel_on    = 1'b1;
                strobe_on = 1'b1;
            end
            ST_HOLD:   sel_on    = 1'b1;
            ST_FINISH: rsp_done  = 1'b1;
            ST_REJECT: begin
                rsp_done = 1'b1;
                rsp_err  = 1'b1;
            end
            default: ;
        endcase
        mem_cs_n = '1;
        if (sel_on) mem_cs_n[bank_q] = 1'b0;
        mem_rd_n     = !(strobe_on && !write_q);
        mem_wr_n     = !(strobe_on && write_q);
        mem_wdata_oe = sel_on && write_q;
        mem_addr     = addr_q;
        mem_wdata    = wdata_q;
    end

    assign rsp_rdata = rdata_q;

    // checks beside the cycle engine
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    assert_accept_selects_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && dec_hit) |=> (mem_cs_n != '1));

    assert_sel_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mem_cs_n) != '1) && (mem_cs_n != '1)) |-> $stable(mem_cs_n));

    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !dec_hit) |=> (rsp_done && rsp_err && (mem_cs_n == '1)));

    assert_strobe_in_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> (mem_cs_n != '1));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_cs_n != '1) || rsp_done) |-> !req_ready);
endmodule

// File: rtl/xbc_top.sv
module xbc_top
    import xbc_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 16,
    parameter int MADR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_bank,
    input  logic [11:0]       cfg_timing,
    output logic [3:0]        mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [MADR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              dec_hit;
    logic [BSEL_W-1:0] dec_bank;
    xbc_timing_t       bank_tim;

    xbc_decode #(
        .ADDR_W (ADDR_W),
        .WIN_W  (MADR_W)
    ) u_decode (
        .addr (req_addr),
        .hit  (dec_hit),
        .bank (dec_bank)
    );

    xbc_timing_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_bank (cfg_bank),
        .wr_val  (cfg_timing),
        .rd_bank (dec_bank),
        .rd_val  (bank_tim)
    );

    xbc_cycle_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MADR_W (MADR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .rsp_done     (rsp_done),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .dec_hit      (dec_hit),
        .dec_bank     (dec_bank),
        .bank_tim     (bank_tim),
        .mem_cs_n     (mem_cs_n),
        .mem_rd_n     (mem_rd_n),
        .mem_wr_n     (mem_wr_n),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe),
        .mem_rdata    (mem_rdata)
    );
endmodule

// File: tb/xbc_top_tb.sv
module xbc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [27:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [11:0] cfg_timing = '0;
    logic [3:0]  mem_cs_n;
    logic        mem_rd_n, mem_wr_n, mem_wdata_oe;
    logic [22:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;
    logic [11:0] shadow [4];

    always #2.5 clk = ~clk;

    // external device model: data depends on the address, valid only while reading
    assign mem_rdata = !mem_rd_n ? (mem_addr[15:0] ^ 16'h5AC3) : 16'hDEAD;

    xbc_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_timing(cfg_timing),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] b, input logic [11:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = b; cfg_timing = v;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[b] = v;
    endtask

    // bench-side window map, written from the requirement text (R1)
    function automatic int exp_bank(input logic [27:0] a);
        if (a >= 28'h020_0000 && a <= 28'h07F_FFFF) return 0;
        if (a >= 28'h400_0000 && a <= 28'h47F_FFFF) return 1;
        if (a >= 28'h800_0000 && a <= 28'h87F_FFFF) return 2;
        if (a >= 28'hC00_0000 && a <= 28'hC7F_FFFF) return 3;
        return -1;
    endfunction

    // one request; poke = keep presenting another request while busy (R7)
    // cfg_same = write new_tim to the target bank in the accept cycle (R8)
    task automatic run_req(input logic [27:0] a, input logic wr, input logic [15:0] wd,
                           input bit poke, input bit cfg_same, input logic [11:0] new_tim);
        int b, n, sel_n, stb_n, pre_n, done_at;
        bit err_seen, bad_sel, bad_addr, bad_wr, bad_rd, bad_rdy;
        logic [11:0] t;
        logic [15:0] rd_v;
        b = exp_bank(a);
        t = (b >= 0) ? shadow[b] : 12'h0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        if (cfg_same && b >= 0) begin
            cfg_we = 1'b1; cfg_bank = 2'(b); cfg_timing = new_tim;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        if (cfg_same && b >= 0) shadow[b] = new_tim;
        if (poke) begin
            req_addr = 28'hC00_0010; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        n = 0; sel_n = 0; stb_n = 0; pre_n = 0; done_at = 0;
        err_seen = 0; bad_sel = 0; bad_addr = 0; bad_wr = 0; bad_rd = 0; bad_rdy = 0;
        rd_v = 16'h0;
        while (n < 100) begin
            n++;
            if (mem_cs_n != 4'hF) begin
                sel_n++;
                if (b < 0 || mem_cs_n != ~(4'b1 << b)) bad_sel = 1;
                if (mem_addr != a[22:0]) bad_addr = 1;
                if (wr && (!mem_wdata_oe || mem_wdata != wd)) bad_wr = 1;
                if (!wr && mem_wdata_oe) bad_wr = 1;
                if (stb_n == 0 && mem_rd_n && mem_wr_n) pre_n++;
            end else if (b < 0 && (!mem_rd_n || !mem_wr_n)) begin
                bad_sel = 1;
            end
            if (!mem_rd_n || !mem_wr_n) begin
                stb_n++;
                if (wr ? (!mem_rd_n) : (!mem_wr_n)) bad_rd = 1;
            end
            if (req_ready) bad_rdy = 1;
            if (rsp_done) begin
                done_at = n; err_seen = rsp_err; rd_v = rsp_rdata;
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (b < 0) begin
            chk(done_at == 1 && err_seen, "R2", "unmapped done+err cycle", done_at, 1);
            chk(sel_n == 0 && !bad_sel, "R2", "no select on unmapped", sel_n, 0);
        end else begin
            chk(!err_seen, "R1", "mapped access without error", err_seen, 0);
            chk(!bad_sel, "R1", "select bit matches bank", mem_cs_n, ~(4'b1 << b));
            chk(sel_n == t[3:0] + t[7:4] + t[11:8] + 3, "R3", "select length", sel_n,
                t[3:0] + t[7:4] + t[11:8] + 3);
            chk(pre_n == t[3:0] + 1, "R3", "setup length", pre_n, t[3:0] + 1);
            chk(stb_n == t[7:4] + 1, "R3", "strobe length", stb_n, t[7:4] + 1);
            chk(done_at == sel_n + 1, "R5", "done right after hold", done_at, sel_n + 1);
            chk(!bad_addr, "R10", "external address", mem_addr, a[22:0]);
            chk(!bad_wr && !bad_rd, "R6", "strobe kind and write data", mem_wdata, wd);
            if (!wr)
                chk(rd_v == (a[15:0] ^ 16'h5AC3), "R5", "read data", rd_v, a[15:0] ^ 16'h5AC3);
        end
        chk(!bad_rdy, "R7", "ready low while busy", bad_rdy, 0);
        @(negedge clk);
        chk(!rsp_done, "R5", "done lasts one cycle", rsp_done, 0);
        chk(mem_cs_n == 4'hF, "R7", "no follow-on cycle from busy request", mem_cs_n, 4'hF);
    endtask

    // vector: addr[47:20] write[19] wdata[18:3] unused[2:0]
    localparam int NV = 14;
    localparam logic [47:0] VEC [NV] = '{
        {28'h020_0000, 1'b0, 16'h0000, 3'd0},
        {28'h07F_FFFF, 1'b1, 16'h1234, 3'd0},
        {28'h01F_FFFF, 1'b0, 16'h0000, 3'd0},
        {28'h080_0000, 1'b1, 16'h4444, 3'd0},
        {28'h400_0000, 1'b0, 16'h0000, 3'd0},
        {28'h47F_FFFF, 1'b1, 16'hBEEF, 3'd0},
        {28'h480_0000, 1'b0, 16'h0000, 3'd0},
        {28'h800_1357, 1'b0, 16'h0000, 3'd0},
        {28'h87F_0000, 1'b1, 16'hA5A5, 3'd0},
        {28'h3FF_FFFF, 1'b0, 16'h0000, 3'd0},
        {28'hC00_0000, 1'b1, 16'h0F0F, 3'd0},
        {28'hC7F_FFFF, 1'b0, 16'h0000, 3'd0},
        {28'hC80_0000, 1'b1, 16'h7777, 3'd0},
        {28'hFFF_FFFF, 1'b0, 16'h0000, 3'd0}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) shadow[i] = 12'h000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(mem_cs_n == 4'hF && mem_rd_n && mem_wr_n, "R9", "selects and strobes idle",
            {mem_cs_n, mem_rd_n, mem_wr_n}, 6'h3F);
        chk(req_ready && !rsp_done && !rsp_err, "R9", "ready high, done/err low",
            {req_ready, rsp_done, rsp_err}, 3'b100);
        // R9 reset timing: all fields zero -> 3-cycle select on bank 1
        run_req(28'h400_0042, 1'b0, 16'h0, 0, 0, 12'h0);

        // R4 distinct per-bank timing
        cfg_write(2'd0, 12'h120);
        cfg_write(2'd1, 12'h000);
        cfg_write(2'd2, 12'h352);
        cfg_write(2'd3, 12'hFFF);

        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v][47:20], VEC[v][19], VEC[v][18:3], 0, 0, 12'h0);
        end

        // R7 request held during a busy cycle is ignored
        run_req(28'h050_0ABC, 1'b0, 16'h0, 1, 0, 12'h0);
        run_req(28'h800_0AAA, 1'b1, 16'hCAFE, 1, 0, 12'h0);

        // R8 timing write to the same bank in the accept cycle
        begin
            logic [11:0] old_t;
            old_t = shadow[2];
            shadow[2] = old_t;
            run_req(28'h800_0100, 1'b0, 16'h0, 0, 1, 12'h0A1);
            shadow[2] = old_t;
        end
        // the run above checked against the old value; the next uses the new one
        shadow[2] = 12'h0A1;
        run_req(28'h800_0101, 1'b0, 16'h0, 0, 0, 12'h0);

        // R4 writing bank 0 leaves bank 3 unchanged
        cfg_write(2'd0, 12'h000);
        run_req(28'hC00_0005, 1'b0, 16'h0, 0, 0, 12'h0);
        run_req(28'h020_0005, 1'b0, 16'h0, 0, 0, 12'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule